// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block keeps a free-running 64-bit time counter and one 64-bit compare register per hart, all reachable over a small register bus. The counter advances by one in each clock cycle where the timebase tick enable is high. Each hart gets a level-sensitive timer interrupt. The interrupt is high whenever that hart's compare value is at or below the current time, using an unsigned comparison.

Software programs a hart's deadline in one of two ways. It can write the two 32-bit halves separately, and each half write merges with the stored other half. Or it can write all 64 bits in one 8-byte access. The time counter can be read as two words or as one 8-byte word. Software cannot write it. Bus reads and errors are combinational in the access cycle. Writes take effect at the clock edge that ends the access cycle.

Top module: `mtimer_cmp_top`

## Requirements
- R1: After reset the time counter and every compare register are zero, so every interrupt line is high.
- R2: The time counter increments by one on each clock edge where `tick` is high, holds otherwise, and wraps modulo 2^64. Its low word reads at TIME_BASE+0 and its high word at TIME_BASE+4.
- R3: Writes to the time counter's address window have no effect on the counter.
- R4: The compare register for slot i (hart FIRST_HART+i) sits at CMP_BASE+8*i. A 4-byte access at slot offset 0 reaches bits 31:0, and one at slot offset 4 reaches bits 63:32.
- R5: A 4-byte write to one half of a compare register replaces only that half, taking the data from `bus_wdata[31:0]`. The other half keeps its stored value.
- R6: An 8-byte access (`bus_size`=3) at slot or time offset 0 reads or writes all 64 bits at once, with bits 31:0 in the lower bus lanes. An 8-byte access at offset 4 reads zero and writes nothing.
- R7: `irq[i]` is high exactly when compare register i is unsigned less than or equal to the time counter.
- R8: A compare write whose new value is already at or below the current time raises the interrupt immediately after that write's clock edge, with no extra tick.
- R9: A read of an unmapped address, a slot beyond the last hart, or an offset other than 0 or 4 returns zero. Writes to any of these change nothing.
- R10: `bus_size` codes 0 (1 byte) and 1 (2 bytes) raise `bus_err` in that cycle, return zero read data and change no register. Codes 2 (4 bytes) and 3 (8 bytes) never raise `bus_err`.
- R11: A 4-byte read returns its word in `bus_rdata[31:0]` with bits 63:32 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase increment enable |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | log2 of the access size in bytes |
| bus_wdata | input | 64 | Write data, little-endian lanes |
| bus_rdata | output | 64 | Read data, zero when no valid read |
| bus_err | output | 1 | Illegal access size this cycle |
| irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench goes after the half-write merge. A design that zeroed or overwrote the other half would read back a wrong 64-bit value, and its interrupt would land at the wrong time. It writes a deadline that is already in the past and checks that the interrupt is up right after the write's edge. A registered or tick-gated compare would show it one cycle late. It probes an 8-byte access at offset 4, an odd offset inside a slot, a slot past the last hart and writes to the time window. Each of these would corrupt state or return stale data if decoded loosely. Illegal sizes mixed into random traffic catch a design that still performs the write while it flags the error.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   // bus_size encoding: log2 of the byte count
   typedef enum logic [1:0] {
      SZ_1 = 2'd0,
      SZ_2 = 2'd1,
      SZ_4 = 2'd2,
      SZ_8 = 2'd3
   } mtc_size_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CMP  = 2'd1,
      HIT_TIME = 2'd2
   } mtc_hit_e;

   typedef enum logic [1:0] {
      PART_NONE = 2'd0,
      PART_LO   = 2'd1,
      PART_HI   = 2'd2,
      PART_FULL = 2'd3
   } mtc_part_e;

   localparam int unsigned HALF_W = 32;
   localparam int unsigned WORD_W = 2 * HALF_W;

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
   import mtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned CMP_BASE  = 'h100,
   parameter int unsigned TIME_BASE = 'h040,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output mtc_hit_e          hit,
   output mtc_part_e         part,
   output logic [IDX_W-1:0]  slot,
   output logic              size_ok
);

   localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(CMP_BASE);
   localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W:0]   SPAN   = (ADDR_W+1)'(NUM_HARTS * 8);

   logic [ADDR_W-1:0] rel;
   logic [2:0]        byte_off;
   logic              in_cmp;
   logic              in_time;

   assign rel      = addr - CMP_A;
   assign byte_off = addr[2:0];
   assign in_cmp   = (addr >= CMP_A) && ({1'b0, rel} < SPAN);
   assign in_time  = (addr[ADDR_W-1:3] == TIME_A[ADDR_W-1:3]);
   assign size_ok  = (size == SZ_4) || (size == SZ_8);

   generate
      if (NUM_HARTS == 1) begin : g_single
         assign slot = '0;
      end else begin : g_multi
         assign slot = rel[IDX_W+2:3];
      end
   endgenerate

   always_comb begin
      part = PART_NONE;
      unique case (size)
         SZ_4: begin
            if (byte_off == 3'd0)      part = PART_LO;
            else if (byte_off == 3'd4) part = PART_HI;
         end
         SZ_8: begin
            if (byte_off == 3'd0)      part = PART_FULL;
         end
         default: part = PART_NONE;
      endcase
   end

   always_comb begin
      hit = HIT_NONE;
      if (part != PART_NONE) begin
         if (in_cmp)       hit = HIT_CMP;
         else if (in_time) hit = HIT_TIME;
      end
   end

   // an address decoded as a compare hit always names an existing slot
   always_comb begin
      if (hit == HIT_CMP) begin
         assert (int'(slot) < NUM_HARTS) else $error("AST_SLOT_RANGE"); // R4
      end
   end

endmodule

// File: rtl/mtc_timebase.sv
module mtc_timebase
   import mtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output logic [WORD_W-1:0] time_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    time_q <= '0;
      else if (tick) time_q <= time_q + 1'b1;
   end

   AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(time_q)); // R2

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (time_q == $past(time_q) + 64'd1)); // R2

endmodule

// File: rtl/mtc_cmp_slot.sv
module mtc_cmp_slot
   import mtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [HALF_W-1:0] lo_d,
   input  logic [HALF_W-1:0] hi_d,
   input  logic [WORD_W-1:0] time_now,
   output logic [WORD_W-1:0] cmp_q,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else begin
         if (lo_we) cmp_q[HALF_W-1:0]      <= lo_d;
         if (hi_we) cmp_q[WORD_W-1:HALF_W] <= hi_d;
      end
   end

   // level output from stored state: no extra stage after a write
   assign irq = (cmp_q <= time_now);

   AST_HALF_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !hi_we) |=> $stable(cmp_q[WORD_W-1:HALF_W])); // R5

   AST_HALF_KEEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && !lo_we) |=> $stable(cmp_q[HALF_W-1:0])); // R5

   AST_PAST_WRITE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && hi_we && ({hi_d, lo_d} <= time_now) && (time_now != '1)) |=> irq); // R8

   AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(lo_we || hi_we) || (time_now < $past(time_now)))); // R7

endmodule

// File: rtl/mtimer_cmp_top.sv
module mtimer_cmp_top
   import mtc_pkg::*;
#(
   parameter int unsigned NUM_HARTS  = 4,
   parameter int unsigned FIRST_HART = 0,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned CMP_BASE   = 'h100,
   parameter int unsigned TIME_BASE  = 'h040
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [63:0]          bus_wdata,
   output logic [63:0]          bus_rdata,
   output logic                 bus_err,
   output logic [NUM_HARTS-1:0] irq
);

   localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam int unsigned CMP_SPAN = NUM_HARTS * 8;

   // elaboration-time parameter checks
   generate
      if (NUM_HARTS < 1)
         $error("NUM_HARTS must be at least 1");
      if ((CMP_BASE % 8) != 0)
         $error("CMP_BASE must be 8-byte aligned");
      if ((TIME_BASE % 8) != 0)
         $error("TIME_BASE must be 8-byte aligned");
      if (ADDR_W < IDX_W + 3 || ADDR_W > 31)
         $error("ADDR_W out of range");
      if (CMP_BASE + CMP_SPAN > (1 << ADDR_W))
         $error("compare window exceeds address space");
      if (TIME_BASE + 8 > (1 << ADDR_W))
         $error("time window exceeds address space");
      if (TIME_BASE + 8 > CMP_BASE && TIME_BASE < CMP_BASE + CMP_SPAN)
         $error("time window overlaps compare window");
      if (FIRST_HART + NUM_HARTS > 4096)
         $error("hart numbering out of range");
   endgenerate

   mtc_hit_e          hit;
   mtc_part_e         part;
   logic [IDX_W-1:0]  slot;
   logic              size_ok;
   logic [WORD_W-1:0] time_q;
   logic [WORD_W-1:0] cmp_arr [NUM_HARTS];
   logic [WORD_W-1:0] cmp_pick;
   logic [WORD_W-1:0] src;
   logic              wr_cmp;

   mtc_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE),
      .IDX_W     (IDX_W)
   ) u_decode (
      .addr    (bus_addr),
      .size    (bus_size),
      .hit     (hit),
      .part    (part),
      .slot    (slot),
      .size_ok (size_ok)
   );

   mtc_timebase u_timebase (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .time_q (time_q)
   );

   assign wr_cmp = bus_sel && bus_we && (hit == HIT_CMP);

   generate
      for (genvar i = 0; i < NUM_HARTS; i++) begin : g_slot
         logic              here;
         logic              lo_we;
         logic              hi_we;
         logic [HALF_W-1:0] hi_d;

         assign here  = wr_cmp && (slot == IDX_W'(i));
         assign lo_we = here && ((part == PART_LO) || (part == PART_FULL));
         assign hi_we = here && ((part == PART_HI) || (part == PART_FULL));
         assign hi_d  = (part == PART_FULL) ? bus_wdata[WORD_W-1:HALF_W]
                                            : bus_wdata[HALF_W-1:0];

         mtc_cmp_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo_we    (lo_we),
            .hi_we    (hi_we),
            .lo_d     (bus_wdata[HALF_W-1:0]),
            .hi_d     (hi_d),
            .time_now (time_q),
            .cmp_q    (cmp_arr[i]),
            .irq      (irq[i])
         );

         AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            bus_err |=> $stable(cmp_arr[i])); // R10
      end
   endgenerate

   always_comb begin
      cmp_pick = '0;
      for (int k = 0; k < NUM_HARTS; k++) begin
         if (slot == IDX_W'(k)) cmp_pick = cmp_arr[k];
      end
   end

   always_comb begin
      unique case (hit)
         HIT_CMP:  src = cmp_pick;
         HIT_TIME: src = time_q;
         default:  src = '0;
      endcase
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         unique case (part)
            PART_LO:   bus_rdata = {32'd0, src[HALF_W-1:0]};
            PART_HI:   bus_rdata = {32'd0, src[WORD_W-1:HALF_W]};
            PART_FULL: bus_rdata = src;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign bus_err = bus_sel && !size_ok;

   AST_ERR_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0)); // R10

   AST_ERR_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_size[1]) |-> !bus_err); // R10

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_size == SZ_4) |-> (bus_rdata[63:32] == 32'd0)); // R11

endmodule

// File: tb/test_mtimer_cmp_top.sv
`timescale 1ns/1ps
module test_mtimer_cmp_top;

   localparam int NH = 4;
   localparam int AW = 12;
   localparam int CB = 'h100;
   localparam int TB = 'h040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_size = 2'd2;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic          bus_err;
   logic [NH-1:0] irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [63:0] time_m;
   logic [63:0] cmp_m [NH];

   always #2 clk = ~clk;

   mtimer_cmp_top #(
      .NUM_HARTS (NH), .FIRST_HART (0), .ADDR_W (AW),
      .CMP_BASE (CB), .TIME_BASE (TB)
   ) i_mtimer_cmp_top (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_size (bus_size), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .bus_err (bus_err), .irq (irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected read data, error flag and the requirement a read exercises
   function automatic logic [63:0] exp_rd(input logic [AW-1:0] a, input logic [1:0] sz,
                                          output bit e, output string tag);
      logic [2:0]  off = a[2:0];
      bit          ok4 = (sz == 2'd2) && (off == 3'd0 || off == 3'd4);
      bit          ok8 = (sz == 2'd3) && (off == 3'd0);
      logic [63:0] v;
      e = 0;
      if (sz < 2'd2) begin
         e = 1; tag = "R10"; return 64'd0;
      end
      if (int'(a) >= CB && int'(a) < CB + 8*NH) begin
         v = cmp_m[(int'(a) - CB) >> 3];
         tag = (sz == 2'd3) ? "R6" : "R4";
      end else if (int'(a[AW-1:3]) == (TB >> 3)) begin
         v = time_m;
         tag = "R2";
      end else begin
         tag = "R9"; return 64'd0;
      end
      if (ok8) return v;
      if (ok4) return (off == 3'd0) ? {32'd0, v[31:0]} : {32'd0, v[63:32]};
      tag = (sz == 2'd3) ? "R6" : "R9";
      return 64'd0;
   endfunction

   task automatic model_write(input logic [AW-1:0] a, input logic [1:0] sz, input logic [63:0] wd);
      int s;
      if (sz < 2'd2) return;
      if (!(int'(a) >= CB && int'(a) < CB + 8*NH)) return;
      s = (int'(a) - CB) >> 3;
      if (sz == 2'd3 && a[2:0] == 3'd0) cmp_m[s] = wd;
      else if (sz == 2'd2 && a[2:0] == 3'd0) cmp_m[s][31:0] = wd[31:0];
      else if (sz == 2'd2 && a[2:0] == 3'd4) cmp_m[s][63:32] = wd[31:0];
   endtask

   task automatic cyc(input bit sel, input bit we, input logic [AW-1:0] a, input logic [1:0] sz,
                      input logic [63:0] wd, input bit tk, input string tag, input string itag);
      bit          e;
      string       at;
      logic [63:0] d;
      logic [NH-1:0] ei;
      @(negedge clk);
      bus_sel = sel; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd; tick = tk;
      #1;
      d = exp_rd(a, sz, e, at);
      if (tag != "") at = tag;
      if (sel) chk(bus_err === e, at, {63'd0, bus_err}, {63'd0, e});
      if (sel && !we) chk(bus_rdata === d, at, bus_rdata, d);
      @(posedge clk);
      #1;
      if (sel && we) model_write(a, sz, wd);
      if (tk) time_m = time_m + 64'd1;
      for (int i = 0; i < NH; i++) ei[i] = (cmp_m[i] <= time_m);
      chk(irq === ei, itag, {60'd0, irq}, {60'd0, ei});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      time_m = '0;
      for (int i = 0; i < NH; i++) cmp_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(irq === 4'hF, "R1", {60'd0, irq}, 64'hF);
      cyc(1, 0, 12'h110, 2'd3, 0, 0, "R1", "R1");
      cyc(1, 0, 12'h040, 2'd3, 0, 0, "R1", "R1");
      // R2: count ticks, hold without them
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 2'd2, 0, 1, "", "R7");
      cyc(1, 0, 12'h040, 2'd3, 0, 0, "R2", "R7");
      cyc(1, 0, 12'h044, 2'd2, 0, 0, "R2", "R7");
      // R3: time writes ignored
      cyc(1, 1, 12'h040, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3", "R7");
      cyc(1, 1, 12'h044, 2'd2, 64'h1234, 0, "R3", "R7");
      cyc(1, 0, 12'h040, 2'd3, 0, 0, "R3", "R7");
      // R6: full write, far future deadline
      cyc(1, 1, 12'h108, 2'd3, 64'h0000_0001_0000_0000, 0, "R6", "R7");
      cyc(1, 0, 12'h10C, 2'd2, 0, 0, "R11", "R7");
      // R5: half writes merge with the other half
      cyc(1, 1, 12'h108, 2'd2, 64'hAAAA_AAAA_0000_1234, 0, "R5", "R7");
      cyc(1, 0, 12'h108, 2'd3, 0, 0, "R5", "R7");
      cyc(1, 1, 12'h10C, 2'd2, 64'h5555_5555_0000_0000, 0, "R5", "R7");
      cyc(1, 0, 12'h108, 2'd3, 0, 0, "R5", "R7");
      // R7: deadline three ticks ahead
      cyc(1, 1, 12'h108, 2'd2, time_m + 64'd3, 0, "R5", "R7");
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 2'd2, 0, 1, "", "R7");
      // R8: deadline in the past fires immediately
      cyc(1, 1, 12'h118, 2'd3, 64'd100, 0, "R6", "R7");
      cyc(1, 1, 12'h118, 2'd3, 64'd2, 0, "R6", "R8");
      // R6: 8-byte at offset 4 reads zero, writes nothing
      cyc(1, 0, 12'h10C, 2'd3, 0, 0, "R6", "R7");
      cyc(1, 1, 12'h114, 2'd3, 64'd0, 0, "R6", "R7");
      // R9: odd offset, slot past the last hart, unmapped
      cyc(1, 0, 12'h102, 2'd2, 0, 0, "R9", "R7");
      cyc(1, 1, 12'h120, 2'd3, 0, 0, "R9", "R7");
      cyc(1, 0, 12'h120, 2'd3, 0, 0, "R9", "R7");
      cyc(1, 1, 12'h30C, 2'd2, 0, 0, "R9", "R7");
      // R10: illegal sizes
      cyc(1, 1, 12'h100, 2'd1, 64'h7777, 0, "R10", "R7");
      cyc(1, 0, 12'h100, 2'd0, 0, 0, "R10", "R7");
      cyc(1, 0, 12'h100, 2'd3, 0, 0, "R10", "R7");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom % 10;
         logic [AW-1:0] a;
         logic [1:0]    sz;
         logic [63:0]   wd;
         if (r < 5) begin
            int offs [6] = '{0, 4, 4, 0, 2, 6};
            a = AW'(CB + 8 * ($urandom % 5) + offs[$urandom % 6]);
         end else if (r < 7) begin
            a = AW'(TB + (($urandom % 3 == 0) ? 1 : 4 * ($urandom % 2)));
         end else begin
            a = AW'($urandom);
         end
         sz = ($urandom % 8 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
         if ($urandom % 4 == 0) wd = {$urandom, $urandom};
         else wd = {32'd0, time_m[31:0] + 32'($urandom % 64) - 32'd32};
         cyc($urandom % 4 != 0, $urandom % 2 == 1, a, sz, wd, $urandom % 3 != 0, "", "R7");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule